// File: doc/BRIEF.md
# Two-Channel Instruction Breakpoint Comparator

This block watches a processor's bus-cycle stream and raises a break request when a cycle meets a programmed condition. It has two channels, A and B, and each works on its own. A channel holds a base address with a per-bit don't-care mask and an optional 8-bit address-space identifier. It also holds a cycle qualifier that selects one of these:

- instruction fetch;
- data read or data write;
- either kind of cycle;
- no cycle at all.

An optional access-size compare can be added to any channel. For fetch matches the break can be taken before the instruction executes, or one cycle after its execute-complete strobe.

Channel B adds two functions. The first compares the data bus under a don't-care mask. The second is an execution count, which lets the first N-1 qualifying matches pass and breaks on the Nth. The break request is the OR of the two channels. Each channel also keeps a sticky match flag that software clears.

Configuration is loaded through a simple word-write port. Each write lands on the rising clock edge.

Top module: `brk_cmp_top`

## Requirements
- R1: A channel's address condition holds when every bus address bit whose mask bit is 0 equals the matching base bit. Mask bits that are 1 are don't-care. Register indices: channel A base 0, A mask 1; channel B base 4, B mask 5.
- R2: When ctrl[8] is 1, the channel also requires bus_asid_i to equal ctrl[7:0]. When ctrl[8] is 0 the identifier is ignored. Channel A ctrl is at index 2 and channel B ctrl at index 6.
- R3: On instruction-fetch cycles, address bit 0 is treated as don't-care. On data cycles, bit 0 is compared under the mask as usual.
- R4: ctrl[10:9] selects the cycle kind. The codes are 00 none (never matches), 01 fetch, 10 data and 11 either. A data cycle also needs ctrl[12] (reads allowed) for a read, or ctrl[13] (writes allowed) for a write.
- R5: ctrl[11] selects the break timing. With ctrl[11]=0, brk_o is asserted combinationally in the cycle of the matching bus_valid_i. With ctrl[11]=1, a matching fetch raises no break in its own cycle. brk_o is then high for exactly the one cycle after the next exec_done_i.
- R6: When B ctrl[18] is 1, each matching cycle decrements the count register (index 9) while its value is above 1. A match that finds the count at 1 breaks, and the count stays at 1. With a count of 5, matches 1 to 4 pass and matches 5 and 6 break.
- R7: When B ctrl[17] is 1, the channel also requires bus_data_i to equal the data register (index 7) on all bits whose data mask bit (index 8) is 0.
- R8: When ctrl[16] is 1, bus_size_i must equal ctrl[15:14]. When ctrl[16] is 0, any size matches.
- R9: brk_o is the OR of the two channels' break hits. A match on one channel has no effect on the other channel's flag.
- R10: match_a_o and match_b_o are sticky. Each is set in the cycle after its channel breaks. A write to index 12 clears flag A when bit 0 is 0, and clears flag B when bit 1 is 0. When a break and a clear fall in the same cycle, the set wins.
- R11: After reset, brk_o, both flags and all configuration are 0. Both cycle kinds are therefore none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | DW | Register write data |
| bus_valid_i | input | 1 | Bus-cycle strobe |
| bus_addr_i | input | AW | Bus address |
| bus_data_i | input | DW | Bus data |
| bus_asid_i | input | 8 | Current address-space identifier |
| bus_fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 2 | Access size code |
| exec_done_i | input | 1 | Execute-complete strobe of the last fetched instruction |
| brk_o | output | 1 | Break request |
| match_a_o | output | 1 | Sticky match flag, channel A |
| match_b_o | output | 1 | Sticky match flag, channel B |

## Verification
Two functions can fall in the same cycle: a software write that clears a sticky flag, and a new break on that same channel. The bench provokes this by issuing the clearing write to index 12 in the same clock as a matching bus cycle. In the cycle after, it checks that the flag stays set, so the set wins. A second write alone must then clear the flag. The execution-count break and the register state it leaves behind are judged the same way: the sixth match must still break, which shows that the count held at 1.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int ASID_W = 8;
  localparam int RA_W   = 4;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_FETCH = 2'b01,
    KIND_DATA  = 2'b10,
    KIND_ANY   = 2'b11
  } kind_e;

  typedef struct packed {
    logic              count_en;  // [18]
    logic              data_en;   // [17]
    logic              size_en;   // [16]
    logic [1:0]        size;      // [15:14]
    logic              wr_en;     // [13]
    logic              rd_en;     // [12]
    logic              after;     // [11]
    kind_e             kind;      // [10:9]
    logic              asid_en;   // [8]
    logic [ASID_W-1:0] asid;      // [7:0]
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [RA_W-1:0] BASE_A   = 4'd0;
  localparam logic [RA_W-1:0] BASE_B   = 4'd4;
  localparam logic [RA_W-1:0] OFS_ADDR = 4'd0;
  localparam logic [RA_W-1:0] OFS_MASK = 4'd1;
  localparam logic [RA_W-1:0] OFS_CTRL = 4'd2;
  localparam logic [RA_W-1:0] OFS_DATA = 4'd3;
  localparam logic [RA_W-1:0] OFS_DMSK = 4'd4;
  localparam logic [RA_W-1:0] OFS_CNT  = 4'd5;
  localparam logic [RA_W-1:0] REG_FLAG = 4'd12;
endpackage

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter bit HAS_DATA = 1'b0
) (
  input  ctrl_t             ctrl_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     amask_i,
  input  logic [DW-1:0]     dbase_i,
  input  logic [DW-1:0]     dmask_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [DW-1:0]     bus_data_i,
  input  logic [ASID_W-1:0] bus_asid_i,
  input  logic              bus_fetch_i,
  input  logic              bus_write_i,
  input  logic [1:0]        bus_size_i,
  output logic              hit_o
);
  logic [AW-1:0] eff_mask;
  logic addr_ok, asid_ok, kind_ok, size_ok, data_ok, rw_ok;

  // fetches are halfword aligned: bit 0 never compared
  assign eff_mask = amask_i | {{(AW-1){1'b0}}, bus_fetch_i};
  assign addr_ok  = ((bus_addr_i ^ base_i) & ~eff_mask) == '0;
  assign asid_ok  = !ctrl_i.asid_en || (bus_asid_i == ctrl_i.asid);
  assign size_ok  = !ctrl_i.size_en || (bus_size_i == ctrl_i.size);
  assign rw_ok    = !bus_fetch_i &&
                    ((ctrl_i.rd_en && !bus_write_i) || (ctrl_i.wr_en && bus_write_i));

  always_comb begin
    unique case (ctrl_i.kind)
      KIND_FETCH: kind_ok = bus_fetch_i;
      KIND_DATA:  kind_ok = rw_ok;
      KIND_ANY:   kind_ok = bus_fetch_i || rw_ok;
      default:    kind_ok = 1'b0;
    endcase
  end

  generate
    if (HAS_DATA) begin : g_data
      assign data_ok = !ctrl_i.data_en || (((bus_data_i ^ dbase_i) & ~dmask_i) == '0);
    end else begin : g_nodata
      logic unused_data;
      assign unused_data = ^{bus_data_i, dbase_i, dmask_i, ctrl_i.data_en};
      assign data_ok = 1'b1;
    end
  endgenerate

  assign hit_o = addr_ok && asid_ok && kind_ok && size_ok && data_ok;
endmodule

// File: rtl/brk_chan.sv
module brk_chan
  import brk_pkg::*;
#(
  parameter int              AW       = 32,
  parameter int              DW       = 32,
  parameter int              CNT_W    = 12,
  parameter bit              HAS_EXT  = 1'b0,
  parameter logic [RA_W-1:0] BASE     = 4'd0,
  parameter int              FLAG_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic              bus_valid_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [DW-1:0]     bus_data_i,
  input  logic [ASID_W-1:0] bus_asid_i,
  input  logic              bus_fetch_i,
  input  logic              bus_write_i,
  input  logic [1:0]        bus_size_i,
  input  logic              exec_done_i,
  output logic              hit_o,
  output logic              flag_o,
  output logic [CNT_W-1:0]  cnt_o
);
  ctrl_t         ctrl_q;
  logic [AW-1:0] base_q, amask_q;
  logic [DW-1:0] dbase, dmask;
  logic          cmp_hit, raw, cnt_ok, fire, fire_after, pend_q, aft_q, clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      base_q  <= '0;
      amask_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == BASE + OFS_ADDR) base_q  <= reg_wdata_i[AW-1:0];
      if (reg_addr_i == BASE + OFS_MASK) amask_q <= reg_wdata_i[AW-1:0];
      if (reg_addr_i == BASE + OFS_CTRL) ctrl_q  <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
    end
  end

  brk_match #(.AW(AW), .DW(DW), .HAS_DATA(HAS_EXT)) u_match (
    .ctrl_i(ctrl_q), .base_i(base_q), .amask_i(amask_q),
    .dbase_i(dbase), .dmask_i(dmask),
    .bus_addr_i(bus_addr_i), .bus_data_i(bus_data_i), .bus_asid_i(bus_asid_i),
    .bus_fetch_i(bus_fetch_i), .bus_write_i(bus_write_i), .bus_size_i(bus_size_i),
    .hit_o(cmp_hit)
  );

  assign raw = bus_valid_i && cmp_hit;

  generate
    if (HAS_EXT) begin : g_ext
      logic [DW-1:0]    dbase_q, dmask_q;
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          dbase_q <= '0;
          dmask_q <= '0;
          cnt_q   <= '0;
        end else begin
          if (reg_we_i && reg_addr_i == BASE + OFS_DATA) dbase_q <= reg_wdata_i;
          if (reg_we_i && reg_addr_i == BASE + OFS_DMSK) dmask_q <= reg_wdata_i;
          if (reg_we_i && reg_addr_i == BASE + OFS_CNT) cnt_q <= reg_wdata_i[CNT_W-1:0];
          else if (raw && ctrl_q.count_en && cnt_q > CNT_W'(1)) cnt_q <= cnt_q - 1'b1;
        end
      end
      assign dbase  = dbase_q;
      assign dmask  = dmask_q;
      assign cnt_o  = cnt_q;
      assign cnt_ok = !ctrl_q.count_en || (cnt_q == CNT_W'(1));
    end else begin : g_plain
      logic unused_cnt;
      assign unused_cnt = ctrl_q.count_en;
      assign dbase  = '0;
      assign dmask  = '0;
      assign cnt_o  = '0;
      assign cnt_ok = 1'b1;
    end
  endgenerate

  assign fire       = raw && cnt_ok;
  assign fire_after = fire && ctrl_q.after && bus_fetch_i;
  assign clr        = reg_we_i && reg_addr_i == REG_FLAG && !reg_wdata_i[FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      aft_q  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      aft_q <= exec_done_i && pend_q;
      if (fire_after)       pend_q <= 1'b1;
      else if (exec_done_i) pend_q <= 1'b0;
      if (hit_o)    flag_o <= 1'b1;
      else if (clr) flag_o <= 1'b0;
    end
  end

  assign hit_o = (fire && !fire_after) || aft_q;
endmodule

// File: rtl/brk_cmp_top.sv
module brk_cmp_top
  import brk_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic              bus_valid_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [DW-1:0]     bus_data_i,
  input  logic [ASID_W-1:0] bus_asid_i,
  input  logic              bus_fetch_i,
  input  logic              bus_write_i,
  input  logic [1:0]        bus_size_i,
  input  logic              exec_done_i,
  output logic              brk_o,
  output logic              match_a_o,
  output logic              match_b_o
);
  logic             hit_a, hit_b;
  logic [CNT_W-1:0] cnt_a, cnt_b;
  logic             unused_cnt_a;

  assign unused_cnt_a = ^cnt_a;

  brk_chan #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .HAS_EXT(1'b0),
             .BASE(BASE_A), .FLAG_BIT(0)) u_chan_a (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .bus_valid_i, .bus_addr_i, .bus_data_i, .bus_asid_i,
    .bus_fetch_i, .bus_write_i, .bus_size_i, .exec_done_i,
    .hit_o(hit_a), .flag_o(match_a_o), .cnt_o(cnt_a)
  );

  brk_chan #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .HAS_EXT(1'b1),
             .BASE(BASE_B), .FLAG_BIT(1)) u_chan_b (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .bus_valid_i, .bus_addr_i, .bus_data_i, .bus_asid_i,
    .bus_fetch_i, .bus_write_i, .bus_size_i, .exec_done_i,
    .hit_o(hit_b), .flag_o(match_b_o), .cnt_o(cnt_b)
  );

  assign brk_o = hit_a || hit_b;
endmodule

// File: rtl/brk_chk.sv
module brk_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_valid_i,
  input logic             exec_done_i,
  input logic             brk_o,
  input logic             match_a_o,
  input logic             match_b_o,
  input logic             clr_a,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_b
);
  assert_flag_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_a_o && !clr_a) |=> match_a_o);

  assert_brk_sets_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |=> (match_a_o || match_b_o));

  assert_brk_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_valid_i && !$past(exec_done_i)) |-> !brk_o);

  assert_cnt_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_b == CNT_W'(1) && !cnt_wr) |=> cnt_b == CNT_W'(1));

  assert_cnt_no_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr |=> cnt_b <= $past(cnt_b));
endmodule

bind brk_cmp_top brk_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_valid_i(bus_valid_i),
  .exec_done_i(exec_done_i), .brk_o(brk_o),
  .match_a_o(match_a_o), .match_b_o(match_b_o),
  .clr_a(reg_we_i && reg_addr_i == brk_pkg::REG_FLAG && !reg_wdata_i[0]),
  .cnt_wr(reg_we_i && reg_addr_i == 4'd9),
  .cnt_b(cnt_b)
);

// File: tb/sim_brk_cmp_top.sv
module sim_brk_cmp_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  ra = '0;
  logic [31:0] wd = '0;
  logic        bv = 1'b0, bf = 1'b0, bw = 1'b0, ed = 1'b0;
  logic [31:0] ba = '0, bd = '0;
  logic [7:0]  bs = '0;
  logic [1:0]  bz = '0;
  logic        brk, fa, fb;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  brk_cmp_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(ra), .reg_wdata_i(wd),
    .bus_valid_i(bv), .bus_addr_i(ba), .bus_data_i(bd), .bus_asid_i(bs),
    .bus_fetch_i(bf), .bus_write_i(bw), .bus_size_i(bz), .exec_done_i(ed),
    .brk_o(brk), .match_a_o(fa), .match_b_o(fb)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // ctrl word per R2, R4, R5, R6, R7, R8 bit positions
  function automatic logic [31:0] mk(input logic [1:0] kind, input logic after,
      input logic rd, input logic wr, input logic aen, input logic [7:0] asid,
      input logic sen, input logic [1:0] sz, input logic den, input logic cen);
    return {13'd0, cen, den, sen, sz, wr, rd, after, kind, aen, asid};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; ra = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  // drive one bus cycle at a negedge, sample brk just after
  task automatic cyc(input logic f, input logic w, input logic [31:0] a,
      input logic [31:0] d, input logic [7:0] s, input logic [1:0] z,
      input logic exp, input string tag);
    @(negedge clk); bv = 1'b1; bf = f; bw = w; ba = a; bd = d; bs = s; bz = z;
    #1 check(brk, exp, tag);
    @(negedge clk); bv = 1'b0;
  endtask

  task automatic idle_both;
    wr(4'd2, 32'd0); wr(4'd6, 32'd0);
    wr(4'd12, 32'd0);
  endtask

  task automatic t_reset;
    #1 check(brk, 1'b0, "R11 brk"); check(fa, 1'b0, "R11 fa"); check(fb, 1'b0, "R11 fb");
    cyc(1'b1, 1'b0, 32'h0, 32'h0, 8'h0, 2'd0, 1'b0, "R11 none after reset");
  endtask

  task automatic t_mask;
    wr(4'd0, 32'h0000_8404); wr(4'd1, 32'h0000_0FFF);
    wr(4'd2, mk(2'b01, 0, 0, 0, 0, 8'h0, 0, 2'd0, 0, 0));
    cyc(1'b1, 1'b0, 32'h0000_8000, 0, 8'h0, 2'd0, 1'b1, "R1 low end");
    cyc(1'b1, 1'b0, 32'h0000_8FFE, 0, 8'h0, 2'd0, 1'b1, "R1 high end");
    cyc(1'b1, 1'b0, 32'h0000_9000, 0, 8'h0, 2'd0, 1'b0, "R1 outside");
    cyc(1'b1, 1'b0, 32'h0001_8404, 0, 8'h0, 2'd0, 1'b0, "R1 upper bit");
    idle_both;
  endtask

  task automatic t_asid;
    wr(4'd0, 32'h0000_8404); wr(4'd1, 32'h0000_0FFF);
    wr(4'd2, mk(2'b01, 0, 0, 0, 1, 8'h80, 0, 2'd0, 0, 0));
    cyc(1'b1, 1'b0, 32'h0000_8100, 0, 8'h80, 2'd0, 1'b1, "R2 asid equal");
    cyc(1'b1, 1'b0, 32'h0000_8100, 0, 8'h70, 2'd0, 1'b0, "R2 asid differs");
    idle_both;
  endtask

  task automatic t_bit0;
    wr(4'd4, 32'h0000_8010); wr(4'd5, 32'h0000_0006);
    wr(4'd6, mk(2'b11, 0, 1, 0, 0, 8'h0, 0, 2'd0, 0, 0));
    cyc(1'b1, 1'b0, 32'h0000_8017, 0, 8'h0, 2'd0, 1'b1, "R3 fetch bit0 ignored");
    cyc(1'b0, 1'b0, 32'h0000_8017, 0, 8'h0, 2'd0, 1'b0, "R3 data bit0 compared");
    cyc(1'b0, 1'b0, 32'h0000_8016, 0, 8'h0, 2'd0, 1'b1, "R3 data in range");
    idle_both;
  endtask

  task automatic t_kind;
    wr(4'd0, 32'h100); wr(4'd1, 32'h0);
    wr(4'd2, mk(2'b00, 0, 1, 1, 0, 8'h0, 0, 2'd0, 0, 0));
    cyc(1'b1, 1'b0, 32'h100, 0, 8'h0, 2'd0, 1'b0, "R4 none fetch");
    cyc(1'b0, 1'b1, 32'h100, 0, 8'h0, 2'd0, 1'b0, "R4 none write");
    wr(4'd2, mk(2'b10, 0, 1, 0, 0, 8'h0, 0, 2'd0, 0, 0));
    cyc(1'b0, 1'b0, 32'h100, 0, 8'h0, 2'd0, 1'b1, "R4 data read");
    cyc(1'b0, 1'b1, 32'h100, 0, 8'h0, 2'd0, 1'b0, "R4 write not enabled");
    cyc(1'b1, 1'b0, 32'h100, 0, 8'h0, 2'd0, 1'b0, "R4 fetch vs data kind");
    idle_both;
  endtask

  task automatic t_after;
    wr(4'd0, 32'h200); wr(4'd1, 32'h0);
    wr(4'd2, mk(2'b01, 1, 0, 0, 0, 8'h0, 0, 2'd0, 0, 0));
    cyc(1'b1, 1'b0, 32'h200, 0, 8'h0, 2'd0, 1'b0, "R5 no break at fetch");
    #1 check(brk, 1'b0, "R5 pending quiet");
    @(negedge clk); ed = 1'b1;
    #1 check(brk, 1'b0, "R5 quiet at exec strobe");
    @(negedge clk); ed = 1'b0;
    #1 check(brk, 1'b1, "R5 break after exec");
    @(negedge clk);
    #1 check(brk, 1'b0, "R5 single cycle");
    idle_both;
  endtask

  task automatic t_count;
    wr(4'd4, 32'h1000); wr(4'd5, 32'h0);
    wr(4'd6, mk(2'b01, 0, 0, 0, 0, 8'h0, 0, 2'd0, 0, 1));
    wr(4'd9, 32'd5);
    for (int i = 1; i <= 4; i++)
      cyc(1'b1, 1'b0, 32'h1000, 0, 8'h0, 2'd0, 1'b0, "R6 early match passes");
    cyc(1'b1, 1'b0, 32'h1002, 0, 8'h0, 2'd0, 1'b0, "R6 other address");
    cyc(1'b1, 1'b0, 32'h1000, 0, 8'h0, 2'd0, 1'b1, "R6 fifth breaks");
    cyc(1'b1, 1'b0, 32'h1000, 0, 8'h0, 2'd0, 1'b1, "R6 count holds at 1");
    idle_both;
  endtask

  task automatic t_data;
    wr(4'd4, 32'h300); wr(4'd5, 32'h0); wr(4'd7, 32'h0); wr(4'd8, 32'h0);
    wr(4'd6, mk(2'b10, 0, 1, 1, 0, 8'h0, 0, 2'd0, 1, 0));
    cyc(1'b0, 1'b1, 32'h300, 32'h0, 8'h0, 2'd0, 1'b1, "R7 data zero");
    cyc(1'b0, 1'b1, 32'h300, 32'h1, 8'h0, 2'd0, 1'b0, "R7 data nonzero");
    wr(4'd7, 32'hAB00); wr(4'd8, 32'h0000_00FF);
    cyc(1'b0, 1'b0, 32'h300, 32'hAB12, 8'h0, 2'd0, 1'b1, "R7 masked low byte");
    cyc(1'b0, 1'b0, 32'h300, 32'hAC12, 8'h0, 2'd0, 1'b0, "R7 unmasked differs");
    idle_both;
  endtask

  task automatic t_size;
    wr(4'd0, 32'h400); wr(4'd1, 32'h0);
    wr(4'd2, mk(2'b10, 0, 1, 0, 0, 8'h0, 1, 2'd2, 0, 0));
    cyc(1'b0, 1'b0, 32'h400, 0, 8'h0, 2'd2, 1'b1, "R8 size equal");
    cyc(1'b0, 1'b0, 32'h400, 0, 8'h0, 2'd1, 1'b0, "R8 size differs");
    wr(4'd2, mk(2'b10, 0, 1, 0, 0, 8'h0, 0, 2'd2, 0, 0));
    cyc(1'b0, 1'b0, 32'h400, 0, 8'h0, 2'd1, 1'b1, "R8 size excluded");
    idle_both;
  endtask

  task automatic t_indep;
    wr(4'd0, 32'h500); wr(4'd1, 32'h0);
    wr(4'd2, mk(2'b01, 0, 0, 0, 0, 8'h0, 0, 2'd0, 0, 0));
    wr(4'd4, 32'h600); wr(4'd5, 32'h0);
    wr(4'd6, mk(2'b01, 0, 0, 0, 0, 8'h0, 0, 2'd0, 0, 0));
    cyc(1'b1, 1'b0, 32'h500, 0, 8'h0, 2'd0, 1'b1, "R9 channel A alone");
    #1 check(fa, 1'b1, "R9 flag A set"); check(fb, 1'b0, "R9 flag B untouched");
    cyc(1'b1, 1'b0, 32'h600, 0, 8'h0, 2'd0, 1'b1, "R9 channel B alone");
    #1 check(fb, 1'b1, "R9 flag B set");
    idle_both;
  endtask

  task automatic t_flag;
    wr(4'd0, 32'h700); wr(4'd1, 32'h0);
    wr(4'd2, mk(2'b01, 0, 0, 0, 0, 8'h0, 0, 2'd0, 0, 0));
    cyc(1'b1, 1'b0, 32'h700, 0, 8'h0, 2'd0, 1'b1, "R10 hit");
    repeat (3) @(negedge clk);
    #1 check(fa, 1'b1, "R10 flag sticky");
    wr(4'd12, 32'h1);
    #1 check(fa, 1'b1, "R10 write 1 keeps flag");
    // clear and match in the same cycle: set wins
    @(negedge clk);
    we = 1'b1; ra = 4'd12; wd = 32'h0;
    bv = 1'b1; bf = 1'b1; bw = 1'b0; ba = 32'h700;
    @(negedge clk); we = 1'b0; bv = 1'b0;
    #1 check(fa, 1'b1, "R10 set beats clear");
    wr(4'd12, 32'h0);
    #1 check(fa, 1'b0, "R10 cleared by 0");
    idle_both;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_mask; t_asid; t_bit0; t_kind; t_after;
    t_count; t_data; t_size; t_indep; t_flag;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule